// File: doc/BRIEF.md
# Floating-Point Load/Store Transfer Sequencer

This block takes one 32-bit floating-point load/store instruction and turns it into a stream of word transfers. It handles two transfer classes: a single-register transfer, whose word count follows from a precision field, and a multiple-register transfer, which moves a whole group of float registers. For every word the block gives the word address, the direction, the float register being moved and the position of the word inside that register. It gives one word per cycle.

The caller presents the instruction, the current base register value and the extended-packed status flag, and pulses `start` while the block is idle. The block then raises `busy` for exactly as many cycles as there are words. After the last word it pulses `done` for one cycle. If the instruction asks for it, the block offers the updated base address for write-back together with `done`. An instruction of neither transfer class never starts a transfer. Instead it pulses `undef` for one cycle.

Top module: `fp_xfer_seq`

## Requirements
- R1: After reset, `busy`, `done`, `undef` and `wb_valid` are all 0.
- R2: The block accepts an instruction only when bits 27:26 are both 1 and bits 11:8 equal 1 (single-register) or 2 (multiple-register). Otherwise a start pulse gives a one-cycle `undef` pulse in the following cycle, and `busy` stays 0.
- R3: For a single-register transfer, the length code L = {bit 22, bit 15} selects the word count: 00 gives 1 word, 01 gives 2 and 10 gives 3. Code 11 gives 3 words when `ext_packed` is 0 and 4 words when it is 1. `freg` stays at bits 14:12.
- R4: For a multiple-register transfer, the same code L gives the register count: 01 gives 1, 10 gives 2, 11 gives 3 and 00 gives 4. Each register takes 3 words. `freg` starts at bits 14:12 and increments modulo 8 after every third word.
- R5: The byte offset is bits 7:0 times 4. It is added when bit 23 is 1 and subtracted when bit 23 is 0. With bit 24 set (pre-index), the first address is the base adjusted by the offset. With bit 24 clear (post-index), the first address is the base itself.
- R6: Each word after the first has an address 4 higher than the word before it. `word_idx` counts 0, 1, … within a register and returns to 0 when a new register begins.
- R7: `busy` rises in the cycle after an accepted start and stays high for exactly the total word count. `done` is high for one cycle, in the cycle right after the last word.
- R8: When bit 21 is set, `wb_valid` pulses together with `done`, and `wb_value` equals the base adjusted by the offset in both indexing modes. When bit 21 is clear, `wb_valid` stays 0.
- R9: `is_load` equals bit 20 of the accepted instruction (1 for load, 0 for store) throughout the transfer.
- R10: The block ignores a start pulse that arrives while `busy` is high. The running transfer is unaffected and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted only while idle |
| instr | input | 32 | Load/store instruction word |
| base | input | 32 | Current base register value |
| ext_packed | input | 1 | Status flag selecting the 4-word packed form |
| addr | output | 32 | Word address of the current transfer word |
| is_load | output | 1 | 1 = load, 0 = store |
| freg | output | 3 | Float register of the current word |
| word_idx | output | 2 | Word position inside the current register |
| busy | output | 1 | High during each transfer word |
| done | output | 1 | One-cycle pulse after the last word |
| undef | output | 1 | One-cycle pulse for a rejected instruction |
| wb_valid | output | 1 | Write-back offer, coincident with done |
| wb_value | output | 32 | Updated base value for write-back |

## Verification
The bench goes after the packed-decimal length, where `ext_packed` decides between 3 and 4 words. A design that ignored the flag would end one word early or one word late. It drives the wrapped register count 00 = four, where a design that read the code as zero would end after zero or three registers. It starts a group transfer at float register 6 or 7, so a missing modulo-8 wrap would show up as a wrong `freg` value. It sets pre-index and post-index against both offset directions, where a mix-up moves the first address or the write-back value by the offset. It also issues a start in the middle of a transfer and tries rejected encodings, which a faulty design would answer with a restart or a spurious `busy`.

// File: rtl/fp_xfer_pkg.sv
package fp_xfer_pkg;
    localparam int MAX_WORDS  = 12;
    localparam int CNT_W      = $clog2(MAX_WORDS);
    localparam int WORDS_PER_MULTI = 3;
    localparam int FREG_W     = 3;
    localparam int WIDX_W     = 2;

    typedef struct packed {
        logic              valid;
        logic              load;
        logic              wback;
        logic [FREG_W-1:0] first_reg;
        logic [WIDX_W-1:0] wpr_m1;
        logic [CNT_W-1:0]  total_m1;
    } xfer_cmd_t;
endpackage

// File: rtl/fp_xfer_decode.sv
module fp_xfer_decode
    import fp_xfer_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [31:0]       instr,
    input  logic [ADDR_W-1:0] base,
    input  logic              ext_packed,
    output xfer_cmd_t         cmd,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] wb_addr
);
    logic [1:0]        len_code;
    logic [3:0]        cp_num;
    logic              is_single, is_multi;
    logic [ADDR_W-1:0] off_bytes;
    logic [ADDR_W-1:0] moved;

    always_comb begin
        len_code  = {instr[22], instr[15]};
        cp_num    = instr[11:8];
        is_single = (instr[27:26] == 2'b11) && (cp_num == 4'd1);
        is_multi  = (instr[27:26] == 2'b11) && (cp_num == 4'd2);
        off_bytes = ADDR_W'({instr[7:0], 2'b00});
        moved     = instr[23] ? (base + off_bytes) : (base - off_bytes);
        first_addr = instr[24] ? moved : base;
        wb_addr    = moved;

        cmd.valid     = is_single || is_multi;
        cmd.load      = instr[20];
        cmd.wback     = instr[21];
        cmd.first_reg = instr[14:12];
        if (is_multi) begin
            cmd.wpr_m1 = WIDX_W'(WORDS_PER_MULTI - 1);
            case (len_code)
                2'b01:   cmd.total_m1 = CNT_W'(1 * WORDS_PER_MULTI - 1);
                2'b10:   cmd.total_m1 = CNT_W'(2 * WORDS_PER_MULTI - 1);
                2'b11:   cmd.total_m1 = CNT_W'(3 * WORDS_PER_MULTI - 1);
                default: cmd.total_m1 = CNT_W'(4 * WORDS_PER_MULTI - 1);
            endcase
        end else begin
            case (len_code)
                2'b00:   cmd.wpr_m1 = 2'd0;
                2'b01:   cmd.wpr_m1 = 2'd1;
                2'b10:   cmd.wpr_m1 = 2'd2;
                default: cmd.wpr_m1 = ext_packed ? 2'd3 : 2'd2;
            endcase
            cmd.total_m1 = CNT_W'(cmd.wpr_m1);
        end
    end
endmodule

// File: rtl/fp_xfer_core.sv
module fp_xfer_core
    import fp_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  xfer_cmd_t         cmd,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] wb_addr,
    output logic [ADDR_W-1:0] addr,
    output logic              is_load,
    output logic [FREG_W-1:0] freg,
    output logic [WIDX_W-1:0] word_idx,
    output logic              busy,
    output logic              done,
    output logic              undef,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_value
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic              undef;
        logic              load;
        logic              wback;
        logic              wb_valid;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] wb_value;
        logic [FREG_W-1:0] freg;
        logic [WIDX_W-1:0] widx;
        logic [WIDX_W-1:0] wpr_m1;
        logic [CNT_W-1:0]  remain;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.done     = 1'b0;
        st_d.undef    = 1'b0;
        st_d.wb_valid = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                if (cmd.valid) begin
                    st_d.busy     = 1'b1;
                    st_d.load     = cmd.load;
                    st_d.wback    = cmd.wback;
                    st_d.addr     = first_addr;
                    st_d.wb_value = wb_addr;
                    st_d.freg     = cmd.first_reg;
                    st_d.widx     = '0;
                    st_d.wpr_m1   = cmd.wpr_m1;
                    st_d.remain   = cmd.total_m1;
                end else begin
                    st_d.undef = 1'b1;
                end
            end
        end else if (st_q.remain == '0) begin
            st_d.busy     = 1'b0;
            st_d.done     = 1'b1;
            st_d.wb_valid = st_q.wback;
        end else begin
            st_d.remain = st_q.remain - 1'b1;
            st_d.addr   = st_q.addr + ADDR_W'(STEP);
            if (st_q.widx == st_q.wpr_m1) begin
                st_d.widx = '0;
                st_d.freg = st_q.freg + 1'b1;
            end else begin
                st_d.widx = st_q.widx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr     = st_q.addr;
    assign is_load  = st_q.load;
    assign freg     = st_q.freg;
    assign word_idx = st_q.widx;
    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign undef    = st_q.undef;
    assign wb_valid = st_q.wb_valid;
    assign wb_value = st_q.wb_value;

    assert_undef_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (!busy && $past(start) && !$past(busy)));

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (addr == $past(addr) + ADDR_W'(STEP)));

    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    assert_wb_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> done);

    assert_load_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(is_load));

    assert_widx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (word_idx <= st_q.wpr_m1));
endmodule

// File: rtl/fp_xfer_seq.sv
module fp_xfer_seq
    import fp_xfer_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic [ADDR_W-1:0] base,
    input  logic              ext_packed,
    output logic [ADDR_W-1:0] addr,
    output logic              is_load,
    output logic [2:0]        freg,
    output logic [1:0]        word_idx,
    output logic              busy,
    output logic              done,
    output logic              undef,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_value
);
    xfer_cmd_t         cmd;
    logic [ADDR_W-1:0] first_addr, wb_addr;

    fp_xfer_decode #(.ADDR_W(ADDR_W)) u_decode (
        .instr      (instr),
        .base       (base),
        .ext_packed (ext_packed),
        .cmd        (cmd),
        .first_addr (first_addr),
        .wb_addr    (wb_addr)
    );

    fp_xfer_core #(.ADDR_W(ADDR_W), .STEP(4)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmd        (cmd),
        .first_addr (first_addr),
        .wb_addr    (wb_addr),
        .addr       (addr),
        .is_load    (is_load),
        .freg       (freg),
        .word_idx   (word_idx),
        .busy       (busy),
        .done       (done),
        .undef      (undef),
        .wb_valid   (wb_valid),
        .wb_value   (wb_value)
    );
endmodule

// File: tb/fp_xfer_seq_bench.sv
module fp_xfer_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base = '0;
    logic        ext_packed = 1'b0;
    logic [31:0] addr, wb_value;
    logic        is_load, busy, done, undef, wb_valid;
    logic [2:0]  freg;
    logic [1:0]  word_idx;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    fp_xfer_seq u_fp_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .base(base),
        .ext_packed(ext_packed), .addr(addr), .is_load(is_load), .freg(freg),
        .word_idx(word_idx), .busy(busy), .done(done), .undef(undef),
        .wb_valid(wb_valid), .wb_value(wb_value)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: run hung, act=%0d exp=<100000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit p, bit u, bit w, bit l, bit lh, bit ll,
                                       logic [2:0] fd, logic [3:0] cp, logic [7:0] off);
        return {4'hE, 3'b110, p, u, lh, w, l, 4'd3, ll, fd, cp, off};
    endfunction

    // Behavioural reference: expected word count and per-word values from the requirements.
    task automatic xfer(logic [31:0] ins, logic [31:0] b, bit ep, bit disturb);
        int per_reg, total;
        int off;
        logic [31:0] moved, first;
        int code;
        code = {ins[22], ins[15]};
        off = int'(ins[7:0]) * 4;
        moved = ins[23] ? b + off : b - off;
        first = ins[24] ? moved : b;
        if (ins[11:8] == 4'd2) begin
            per_reg = 3;
            total = 3 * ((code == 0) ? 4 : code);
        end else begin
            per_reg = (code == 3) ? (ep ? 4 : 3) : code + 1;
            total = per_reg;
        end
        @(negedge clk);
        instr = ins; base = b; ext_packed = ep; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < total; i++) begin
            if (disturb && i == 0) begin
                instr = mk(1, 1, 1, 0, 1, 1, 3'd0, 4'd1, 8'h10);
                start = 1'b1;
            end
            chk("R7 busy", busy, 1);
            chk("R5/R6 addr", addr, first + 32'(4 * i));
            chk((ins[11:8] == 2) ? "R4 freg" : "R3 freg", freg, 32'((ins[14:12] + i / per_reg) % 8));
            chk("R6 word_idx", word_idx, 32'(i % per_reg));
            chk("R9 is_load", is_load, ins[20]);
            chk("R2 undef", undef, 0);
            @(negedge clk);
            start = 1'b0;
        end
        chk("R7 busy end", busy, 0);
        chk("R7 done", done, 1);
        chk("R8 wb_valid", wb_valid, ins[21]);
        if (ins[21]) chk("R8 wb_value", wb_value, moved);
        @(negedge clk);
        chk("R7 done pulse", done, 0);
        chk("R10 no restart", busy, 0);
        chk("R8 wb_valid pulse", wb_valid, 0);
    endtask

    task automatic reject(logic [31:0] ins);
        @(negedge clk);
        instr = ins; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 undef", undef, 1);
        chk("R2 busy", busy, 0);
        @(negedge clk);
        chk("R2 undef pulse", undef, 0);
        chk("R2 busy stays", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 undef", undef, 0);
        chk("R1 wb_valid", wb_valid, 0);
        rst_n = 1'b1;
        // R3 single lengths
        xfer(mk(1, 1, 0, 1, 0, 0, 3'd2, 4'd1, 8'h04), 32'h1000, 0, 0);
        xfer(mk(1, 0, 1, 0, 0, 1, 3'd5, 4'd1, 8'h02), 32'h2000, 0, 0);
        xfer(mk(0, 1, 1, 1, 1, 0, 3'd1, 4'd1, 8'h03), 32'h3000, 1, 0);
        xfer(mk(1, 1, 0, 1, 1, 1, 3'd0, 4'd1, 8'h00), 32'h4000, 0, 0);
        xfer(mk(1, 1, 1, 1, 1, 1, 3'd7, 4'd1, 8'hFF), 32'h4000, 1, 0);
        // R4 multiple counts incl. wrap of freg and 00 = four
        xfer(mk(1, 1, 1, 1, 0, 1, 3'd3, 4'd2, 8'h03), 32'h5000, 0, 0);
        xfer(mk(0, 0, 1, 0, 1, 0, 3'd7, 4'd2, 8'h06), 32'h6000, 0, 0);
        xfer(mk(1, 0, 0, 1, 1, 1, 3'd6, 4'd2, 8'h09), 32'h7000, 1, 0);
        xfer(mk(0, 1, 1, 0, 0, 0, 3'd6, 4'd2, 8'h0C), 32'h8000, 0, 0);
        // R10 start while busy
        xfer(mk(1, 1, 1, 1, 0, 1, 3'd4, 4'd2, 8'h01), 32'h9000, 0, 1);
        xfer(mk(0, 0, 0, 0, 0, 0, 3'd0, 4'd1, 8'h01), 32'h0000_0004, 0, 1);
        // R2 rejects
        reject(mk(1, 1, 0, 1, 0, 0, 3'd0, 4'd3, 8'h01));
        reject(mk(1, 1, 0, 1, 0, 0, 3'd0, 4'd0, 8'h01));
        reject(mk(1, 1, 0, 1, 0, 0, 3'd0, 4'd1, 8'h01) & 32'hF7FF_FFFF);
        reject(mk(1, 1, 0, 1, 0, 0, 3'd0, 4'd2, 8'h01) & 32'hFBFF_FFFF);
        xfer(mk(1, 1, 0, 0, 0, 1, 3'd1, 4'd1, 8'h01), 32'hA000, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule